// File: doc/BRIEF.md
# Dual-Lane Fixed-Point Multiply-Accumulate Datapath

This block is a two-lane signed fixed-point multiply-accumulate engine. Each lane multiplies a pair of signed 16-bit operands and either loads, adds or subtracts the product into its own 40-bit accumulator. One opcode, issued with a start strobe, steers both lanes together, so the two lanes always perform the same kind of computation on their own operand pairs. A lane never splits into narrower sub-operations; parallelism exists only across the two lanes.

The same hardware also performs a sequenced 32 x 32 multiply. The two lanes' operand inputs are concatenated into two 32-bit signed values, and lane 0's multiplier is reused over four partial-product steps (low-low, low-high, high-low, high-high) followed by a write-back step. The low 32 bits of the full product are sign-extended into accumulator 0. While the sequence runs, `busy` is high and further start strobes are dropped; `done` pulses when the result lands. A synchronous clear zeroes both accumulators.

The sequencer is a named state machine: `ST_IDLE` goes to `ST_LL` on an accepted wide start; `ST_LL` goes to `ST_LH`, then `ST_HL`, then `ST_HH`, then `ST_FIN`, and `ST_FIN` returns to `ST_IDLE` unconditionally.

Top module: `dual_mac_unit`

## Requirements
- R1: With `op` = 2'b00 (load) and `start` high while not busy, each accumulator takes the signed product of its lane's operands sign-extended to 40 bits, visible after the next rising edge.
- R2: With `op` = 2'b01 (add), each accumulator adds its lane's sign-extended product to its previous value on the next edge.
- R3: With `op` = 2'b10 (subtract), each accumulator subtracts its lane's sign-extended product; add and subtract wrap modulo 2^40 without saturation.
- R4: Both lanes obey the single opcode of an issue in the same cycle, each on its own operand pair.
- R5: With `op` = 2'b11 (wide) and `start` high while not busy, acc0 receives the sign-extended low 32 bits of the signed product of {a1,a0} and {b1,b0}; acc0 changes and `done` rises together after the fifth rising edge following the accepting edge's cycle (i.e. six edges after start is sampled, counting the accepting edge), and `done` is high for exactly one cycle.
- R6: During a wide operation `busy` is high for exactly five cycles, any start strobe is ignored, and acc1 does not change unless cleared.
- R7: `clear` high sets both accumulators to zero at the next edge and takes priority over any issued operation or wide write-back in that cycle.
- R8: After reset both accumulators are zero and `busy` and `done` are low.
- R9: Load, add and subtract complete in one cycle and never raise `busy` or `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe for the opcode on `op` |
| clear | input | 1 | Synchronous zeroing of both accumulators |
| op | input | 2 | 00 load, 01 add, 10 subtract, 11 wide 32x32 multiply |
| a0 | input | 16 | Lane 0 first operand; low half of wide operand A |
| b0 | input | 16 | Lane 0 second operand; low half of wide operand B |
| a1 | input | 16 | Lane 1 first operand; high half of wide operand A |
| b1 | input | 16 | Lane 1 second operand; high half of wide operand B |
| acc0 | output | 40 | Lane 0 accumulator |
| acc1 | output | 40 | Lane 1 accumulator |
| busy | output | 1 | Wide multiply in progress |
| done | output | 1 | One-cycle pulse when the wide result is written |

## Verification
The properties assume that the operand inputs are meaningful only in the cycle `start` is sampled and that `clear` may arrive at any time, including during a wide sequence; they make no assumption about `start` during `busy`. The stimulus therefore holds operands only for the issue cycle, deliberately raises `start` with a different opcode while a wide multiply runs, and mixes occasional clear strobes into random single-cycle traffic so the priority rule is exercised without breaking the model's tracking.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_WIDE = 2'b11
    } mac_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL,
        ST_LH,
        ST_HL,
        ST_HH,
        ST_FIN
    } seq_st_e;
endpackage

// File: rtl/dmac_lane.sv
module dmac_lane
    import dmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            issue,
    input  mac_op_e         op,
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    input  logic            ext_x,
    input  logic            ext_y,
    input  logic            wr_wide,
    input  logic [2*DW-1:0] wide_val,
    output logic [2*DW-1:0] prod_lo,
    output logic [AW-1:0]   acc
);
    localparam int PW = 2 * DW + 2;
    localparam int RW = 2 * DW;

    logic signed [DW:0]   xs, ys;
    logic signed [PW-1:0] prod;
    logic [AW-1:0]        prod_ext, wide_ext, acc_nxt;

    // Operand top bit: sign copy for signed halves, zero for unsigned halves
    assign xs = {ext_x & x[DW-1], x};
    assign ys = {ext_y & y[DW-1], y};
    assign prod = xs * ys;
    assign prod_lo = prod[RW-1:0];

    assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
    assign wide_ext = {{(AW-RW){wide_val[RW-1]}}, wide_val};

    always_comb begin
        acc_nxt = acc;
        if (clear) begin
            acc_nxt = '0;
        end else if (wr_wide) begin
            acc_nxt = wide_ext;
        end else if (issue) begin
            unique case (op)
                OP_LOAD: acc_nxt = prod_ext;
                OP_ADD:  acc_nxt = acc + prod_ext;
                OP_SUB:  acc_nxt = acc - prod_ext;
                default: acc_nxt = acc;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_nxt;
    end
endmodule

// File: rtl/dmac_wide_seq.sv
module dmac_wide_seq
    import dmac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [2*DW-1:0] opa,
    input  logic [2*DW-1:0] opb,
    input  logic [2*DW-1:0] pp_lo,
    output logic            busy,
    output logic            done,
    output logic            wr_wide,
    output logic [DW-1:0]   x,
    output logic [DW-1:0]   y,
    output logic            ext_x,
    output logic            ext_y,
    output logic [2*DW-1:0] result
);
    localparam int RW = 2 * DW;

    seq_st_e       st, st_nxt;
    logic [RW-1:0] a_q, b_q, sum_q, pp_shift;
    logic [1:0]    shf;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Transitions
    always_comb begin
        unique case (st)
            ST_IDLE: st_nxt = launch ? ST_LL : ST_IDLE;
            ST_LL:   st_nxt = ST_LH;
            ST_LH:   st_nxt = ST_HL;
            ST_HL:   st_nxt = ST_HH;
            ST_HH:   st_nxt = ST_FIN;
            ST_FIN:  st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Per-state multiplier steering
    always_comb begin
        x     = '0;
        y     = '0;
        ext_x = 1'b0;
        ext_y = 1'b0;
        shf   = 2'd0;
        unique case (st)
            ST_LL: begin
                x = a_q[DW-1:0];  y = b_q[DW-1:0];
            end
            ST_LH: begin
                x = a_q[DW-1:0];  y = b_q[RW-1:DW];
                ext_y = 1'b1;     shf = 2'd1;
            end
            ST_HL: begin
                x = a_q[RW-1:DW]; y = b_q[DW-1:0];
                ext_x = 1'b1;     shf = 2'd1;
            end
            ST_HH: begin
                x = a_q[RW-1:DW]; y = b_q[RW-1:DW];
                ext_x = 1'b1;     ext_y = 1'b1; shf = 2'd2;
            end
            default: ;
        endcase
    end

    // Partial product aligned into the low result word
    always_comb begin
        unique case (shf)
            2'd0:    pp_shift = pp_lo;
            2'd1:    pp_shift = {pp_lo[DW-1:0], {DW{1'b0}}};
            default: pp_shift = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            sum_q <= '0;
            done  <= 1'b0;
        end else begin
            if (launch) begin
                a_q <= opa;
                b_q <= opb;
            end
            if (st == ST_LL)
                sum_q <= pp_shift;
            else if (st == ST_LH || st == ST_HL || st == ST_HH)
                sum_q <= sum_q + pp_shift;
            done <= (st == ST_FIN);
        end
    end

    assign busy    = (st != ST_IDLE);
    assign wr_wide = (st == ST_FIN);
    assign result  = sum_q;
endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
    import dmac_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clear,
    input  logic [1:0]    op,
    input  logic [DW-1:0] a0,
    input  logic [DW-1:0] b0,
    input  logic [DW-1:0] a1,
    input  logic [DW-1:0] b1,
    output logic [AW-1:0] acc0,
    output logic [AW-1:0] acc1,
    output logic          busy,
    output logic          done
);
    localparam int LANES = 2;
    localparam int RW    = 2 * DW;

    mac_op_e       op_e;
    logic          issue, launch, wr_wide;
    logic [DW-1:0] sx, sy;
    logic          sex, sey;
    logic [RW-1:0] wide_res;

    logic [DW-1:0] lx  [LANES];
    logic [DW-1:0] ly  [LANES];
    logic          lex [LANES];
    logic          ley [LANES];
    logic [RW-1:0] llo [LANES];
    logic [AW-1:0] lacc[LANES];

    assign op_e   = mac_op_e'(op);
    assign issue  = start && !busy && (op_e != OP_WIDE);
    assign launch = start && !busy && (op_e == OP_WIDE);

    always_comb begin
        lx[0]  = busy ? sx  : a0;
        ly[0]  = busy ? sy  : b0;
        lex[0] = busy ? sex : 1'b1;
        ley[0] = busy ? sey : 1'b1;
        lx[1]  = a1;
        ly[1]  = b1;
        lex[1] = 1'b1;
        ley[1] = 1'b1;
    end

    dmac_wide_seq #(.DW(DW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .opa     ({a1, a0}),
        .opb     ({b1, b0}),
        .pp_lo   (llo[0]),
        .busy    (busy),
        .done    (done),
        .wr_wide (wr_wide),
        .x       (sx),
        .y       (sy),
        .ext_x   (sex),
        .ext_y   (sey),
        .result  (wide_res)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmac_lane #(.DW(DW), .AW(AW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .issue    (issue),
            .op       (op_e),
            .x        (lx[g]),
            .y        (ly[g]),
            .ext_x    (lex[g]),
            .ext_y    (ley[g]),
            .wr_wide  ((g == 0) ? wr_wide : 1'b0),
            .wide_val (wide_res),
            .prod_lo  (llo[g]),
            .acc      (lacc[g])
        );
    end

    assign acc0 = lacc[0];
    assign acc1 = lacc[1];
endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          clear,
    input logic [1:0]    op,
    input logic [DW-1:0] a0,
    input logic [DW-1:0] b0,
    input logic [DW-1:0] a1,
    input logic [DW-1:0] b1,
    input logic [AW-1:0] acc0,
    input logic [AW-1:0] acc1,
    input logic          busy,
    input logic          done
);
    logic signed [AW-1:0] e0, e1;
    logic [2:0]           run_cnt;

    assign e0 = $signed(a0) * $signed(b0);
    assign e1 = $signed(a1) * $signed(b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 3'd1;
        else           run_cnt <= '0;
    end

    a_r1_load_both: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !clear && op == 2'b00) |=> (acc0 == $past(e0) && acc1 == $past(e1)));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc0 == '0 && acc1 == '0));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < 3'd5));

    a_r6_lane1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear) |=> $stable(acc1));

    a_r9_short_ops: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'b11) |=> (!busy && !done));
endmodule

bind dual_mac_unit dmac_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .op(op),
    .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .acc0(acc0), .acc1(acc1), .busy(busy), .done(done)
);

// File: tb/tb_dual_mac_unit.sv
module tb_dual_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clear = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
    logic [39:0] acc0, acc1;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    logic [39:0] m0 = '0, m1 = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .op(op),
        .a0(a0), .b0(b0), .a1(a1), .b1(b1),
        .acc0(acc0), .acc1(acc1), .busy(busy), .done(done)
    );

    function automatic logic [39:0] sprod(logic [15:0] a, logic [15:0] b);
        logic signed [39:0] p;
        p = $signed(a) * $signed(b);
        return p;
    endfunction

    function automatic logic [39:0] wprod(logic [31:0] a, logic [31:0] b);
        logic signed [63:0] f;
        f = $signed(a) * $signed(b);
        return {{8{f[31]}}, f[31:0]};
    endfunction

    task automatic chk(string req, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic short_op(logic [1:0] o, logic [15:0] x0, logic [15:0] y0,
                            logic [15:0] x1, logic [15:0] y1, logic clr, string req);
        op = o; a0 = x0; b0 = y0; a1 = x1; b1 = y1; clear = clr; start = 1'b1;
        @(negedge clk);
        start = 1'b0; clear = 1'b0;
        if (clr) begin
            m0 = '0; m1 = '0;
        end else begin
            case (o)
                2'b00: begin m0 = sprod(x0, y0);      m1 = sprod(x1, y1);      end
                2'b01: begin m0 = m0 + sprod(x0, y0); m1 = m1 + sprod(x1, y1); end
                default: begin m0 = m0 - sprod(x0, y0); m1 = m1 - sprod(x1, y1); end
            endcase
        end
        chk({req, " acc0"}, acc0, m0);
        chk({req, " acc1"}, acc1, m1);
        chk("R9 busy", {39'd0, busy}, 40'd0);
        chk("R9 done", {39'd0, done}, 40'd0);
    endtask

    task automatic wide_op(logic [31:0] wa, logic [31:0] wb);
        op = 2'b11; a0 = wa[15:0]; a1 = wa[31:16]; b0 = wb[15:0]; b1 = wb[31:16];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            chk("R6 busy held", {39'd0, busy}, 40'd1);
            chk("R5 done early", {39'd0, done}, 40'd0);
            if (i == 1) begin
                // R6: start during busy must be dropped
                op = 2'b00; a1 = 16'h7fff; b1 = 16'h7fff; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        m0 = wprod(wa, wb);
        chk("R6 busy released", {39'd0, busy}, 40'd0);
        chk("R5 done pulse", {39'd0, done}, 40'd1);
        chk("R5 wide result", acc0, m0);
        chk("R6 acc1 kept", acc1, m1);
        @(negedge clk);
        chk("R5 done one cycle", {39'd0, done}, 40'd0);
        chk("R6 ignored start", acc1, m1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 acc0", acc0, 40'd0);
        chk("R8 acc1", acc1, 40'd0);
        chk("R8 busy", {39'd0, busy}, 40'd0);
        chk("R8 done", {39'd0, done}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4: load with different lane operands
        short_op(2'b00, 16'h8000, 16'h8000, 16'h0003, 16'hfffb, 1'b0, "R1 R4 load");
        short_op(2'b01, 16'h7fff, 16'h8000, 16'hffff, 16'hffff, 1'b0, "R2 add");
        short_op(2'b10, 16'h1234, 16'h0056, 16'h8000, 16'h7fff, 1'b0, "R3 sub");
        // R7: clear beats an issued add
        short_op(2'b01, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 1'b1, "R7 clear priority");
        // R3: subtract below zero, then wrap by repeated maximal adds
        short_op(2'b10, 16'h0001, 16'h0001, 16'h0002, 16'h0003, 1'b0, "R3 sub negative");
        for (int k = 0; k < 520; k++) begin
            op = 2'b01; a0 = 16'h8000; b0 = 16'h8000; a1 = 16'h8000; b1 = 16'h7fff;
            start = 1'b1;
            @(negedge clk);
            m0 = m0 + sprod(16'h8000, 16'h8000);
            m1 = m1 + sprod(16'h8000, 16'h7fff);
        end
        start = 1'b0;
        chk("R3 wrap acc0", acc0, m0);
        chk("R3 wrap acc1", acc1, m1);

        // R5/R6: directed wide multiplies
        wide_op(32'h8000_0000, 32'h8000_0000);
        wide_op(32'hffff_ffff, 32'h0000_0007);
        wide_op(32'h1234_5678, 32'h9abc_def0);
        wide_op(32'h7fff_ffff, 32'h7fff_ffff);
        short_op(2'b01, 16'h0010, 16'h0010, 16'h0020, 16'h0020, 1'b0, "R2 after wide");

        // Mixed random traffic
        for (int n = 0; n < 300; n++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 2));
            short_op(o, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                     ($urandom_range(0, 15) == 0), "R4 random");
            if (n % 25 == 0) wide_op($urandom, $urandom);
        end

        // R7: clear alone
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        chk("R7 clear acc0", acc0, 40'd0);
        chk("R7 clear acc1", acc1, 40'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule